// File: doc/BRIEF.md
# Interrupt Cause Status Word

This block holds the 16-bit status word of a network controller. Single-cycle event pulses from the transmit, receive and flow-control logic are caught in eight sticky cause bits, the upper byte of the word. The lower byte shows the current state codes of the command unit and the receive unit. Those codes come in as inputs from state machines outside this block.

Software reads the whole word at any time on `rdata_o`. It acknowledges causes by writing ones to the upper byte through a write strobe with two byte enables. The lower byte is read-only. One level-sensitive interrupt line stays high while any cause bit is pending. It drops only after software has cleared every pending cause, in one write or over several.

Two causes have special gating. The flow-control pause cause can be removed at build time for configurations without flow control. The failed-transmit cause latches only while its enable input is high. That input is meant to be held low unless software asks for such interrupts.

Top module: `irq_cause_word`

## Requirements
- R1: `rdata_o` carries the cause bits in [15:8], `cmd_state_i` in [7:6] and `rx_state_i` in [5:2]. Bits [1:0] read as zero. The lower byte follows its inputs in the same cycle.
- R2: An event pulse on `evt_i[k]` sampled at a clock edge sets word bit 8+k from that edge on. The bit stays set after the pulse ends until it is acknowledged.
- R3: A write (`wr_i`=1, `be_i[1]`=1) clears each set cause bit whose `wdata_i` bit is 1. Bits written with 0 keep their value.
- R4: Writing 1 to a cause bit that is not set leaves it clear and leaves `irq_o` unchanged.
- R5: When several causes are pending and only some are acknowledged, `irq_o` stays high. It falls only on the edge that clears the last pending cause.
- R6: If an event and an acknowledge hit the same cause bit at the same edge, the bit stays set.
- R7: `irq_o` is high exactly when at least one cause bit is set. A new event that arrives while `irq_o` is high leaves it high without a low gap.
- R8: With parameter `HAS_PAUSE`=0, word bit 8 (pause-frame cause, `evt_i[0]`) never sets and always reads 0.
- R9: Word bit 9 (failed-transmit cause, `evt_i[1]`) sets only when `txfail_en_i` is high at the edge where the event is sampled.
- R10: A write with `be_i[1]`=0 changes no cause bit, whatever `be_i[0]` and `wdata_i` are. The lower byte never takes write data.
- R11: While reset is active, and for as long as the reset synchronizer is still holding the internal reset, all cause bits are 0 and `irq_o` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| evt_i | input | 8 | Event pulses; bit k feeds word bit 8+k (bit 0 pause frame, bit 1 failed transmit) |
| txfail_en_i | input | 1 | Allows the failed-transmit cause to latch |
| cmd_state_i | input | 2 | Command-unit state code |
| rx_state_i | input | 4 | Receive-unit state code |
| wr_i | input | 1 | Write strobe, one cycle per write |
| be_i | input | 2 | Byte enables; bit 1 selects the cause byte |
| wdata_i | input | 16 | Write data; ones in [15:8] acknowledge causes |
| rdata_o | output | 16 | Status word |
| irq_o | output | 1 | Level interrupt request |

## Verification
The assertions assume that every input is synchronous to the clock and stable around its rising edge. They also assume that a write lasts exactly one cycle, so each cycle with `wr_i` high counts as a separate acknowledge. The bench changes all inputs only on the falling edge. It draws events, strobes, enables and data from a seeded generator, so simultaneous events and acknowledges, writes to pending and non-pending bits, and lower-byte-only writes all occur together.

// File: rtl/irq_cause_pkg.sv
package irq_cause_pkg;

  localparam int CAUSE_W    = 8;
  localparam int CMD_W      = 2;
  localparam int RX_W       = 4;
  localparam int PAD_W      = 2;
  localparam int WORD_W     = CAUSE_W + CMD_W + RX_W + PAD_W;
  localparam int BE_W       = WORD_W / 8;
  localparam int PAUSE_IDX  = 0;
  localparam int TXFAIL_IDX = 1;

  typedef struct packed {
    logic [CAUSE_W-1:0] cause;
    logic [CMD_W-1:0]   cmd_state;
    logic [RX_W-1:0]    rx_state;
    logic [PAD_W-1:0]   pad;
  } status_word_t;

endpackage

// File: rtl/irq_rst_sync.sv
module irq_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_no = sync_q[STAGES-1];

endmodule

// File: rtl/irq_cause_bit.sv
module irq_cause_bit (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);

  logic q_q;
  logic q_d;
  logic q_en;

  always_comb begin
    q_en = set_i | clr_i;
    if (set_i) begin
      q_d = 1'b1;
    end else begin
      q_d = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q_q <= 1'b0;
    end else if (q_en) begin
      q_q <= q_d;
    end
  end

  assign q_o = q_q;

  // R2 and R6: an event always leaves the bit set
  a_r2_event_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> q_o);

  // R2: sticky without an acknowledge
  a_r2_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (q_o && !clr_i) |=> q_o);

  // R3: an acknowledge without an event clears the bit
  a_r3_ack_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !set_i) |=> !q_o);

  // R4: a clear bit never sets without an event
  a_r4_no_spurious: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!q_o && !set_i) |=> !q_o);

endmodule

// File: rtl/irq_bus_decode.sv
module irq_bus_decode
  import irq_cause_pkg::*;
(
  input  logic                wr_i,
  input  logic [BE_W-1:0]     be_i,
  input  logic [WORD_W-1:0]   wdata_i,
  input  logic [CAUSE_W-1:0]  cause_i,
  input  logic [CMD_W-1:0]    cmd_state_i,
  input  logic [RX_W-1:0]     rx_state_i,
  output logic [CAUSE_W-1:0]  ack_o,
  output logic [WORD_W-1:0]   rdata_o
);

  localparam int HI_BE = BE_W - 1;

  status_word_t word;

  always_comb begin
    if (wr_i && be_i[HI_BE]) begin
      ack_o = wdata_i[WORD_W-1 -: CAUSE_W];
    end else begin
      ack_o = '0;
    end
  end

  always_comb begin
    word.cause     = cause_i;
    word.cmd_state = cmd_state_i;
    word.rx_state  = rx_state_i;
    word.pad       = '0;
    rdata_o        = word;
  end

endmodule

// File: rtl/irq_cause_word.sv
module irq_cause_word
  import irq_cause_pkg::*;
#(
  parameter bit HAS_PAUSE = 1'b1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [CAUSE_W-1:0]  evt_i,
  input  logic                txfail_en_i,
  input  logic [CMD_W-1:0]    cmd_state_i,
  input  logic [RX_W-1:0]     rx_state_i,
  input  logic                wr_i,
  input  logic [BE_W-1:0]     be_i,
  input  logic [WORD_W-1:0]   wdata_i,
  output logic [WORD_W-1:0]   rdata_o,
  output logic                irq_o
);

  logic               rst_n;
  logic [CAUSE_W-1:0] ack;
  logic [CAUSE_W-1:0] evt_gated;
  logic [CAUSE_W-1:0] cause;

  irq_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rst_no (rst_n)
  );

  irq_bus_decode u_bus (
    .wr_i        (wr_i),
    .be_i        (be_i),
    .wdata_i     (wdata_i),
    .cause_i     (cause),
    .cmd_state_i (cmd_state_i),
    .rx_state_i  (rx_state_i),
    .ack_o       (ack),
    .rdata_o     (rdata_o)
  );

  for (genvar k = 0; k < CAUSE_W; k++) begin : g_cause
    if (k == PAUSE_IDX && !HAS_PAUSE) begin : g_tied
      assign evt_gated[k] = 1'b0;
      assign cause[k]     = 1'b0;
    end else begin : g_live
      if (k == TXFAIL_IDX) begin : g_txf
        assign evt_gated[k] = evt_i[k] & txfail_en_i;
      end else begin : g_plain
        assign evt_gated[k] = evt_i[k];
      end
      irq_cause_bit u_bit (
        .clk_i  (clk_i),
        .rst_ni (rst_n),
        .set_i  (evt_gated[k]),
        .clr_i  (ack[k]),
        .q_o    (cause[k])
      );
    end
  end

  assign irq_o = |cause;

  // R5: the line only falls on an edge that carried an acknowledge
  a_r5_release_on_ack: assert property (@(posedge clk_i) disable iff (!rst_n)
    $fell(irq_o) |-> $past(|ack));

  // R7: no low gap while no acknowledge is written
  a_r7_irq_hold: assert property (@(posedge clk_i) disable iff (!rst_n)
    (irq_o && !(|ack)) |=> irq_o);

  // R9: disabled failed-transmit cause stays clear
  a_r9_txfail_gate: assert property (@(posedge clk_i) disable iff (!rst_n)
    (!txfail_en_i && !rdata_o[8+TXFAIL_IDX] && !ack[TXFAIL_IDX]) |=> !rdata_o[8+TXFAIL_IDX]);

  // R10: writes without the upper enable acknowledge nothing
  a_r10_no_upper_write: assert property (@(posedge clk_i) disable iff (!rst_n)
    (wr_i && !be_i[BE_W-1] && irq_o) |=> irq_o);

  // R11: internal reset holds the word clear
  a_r11_reset_clear: assert property (@(posedge clk_i)
    !rst_n |-> (cause == '0 && !irq_o));

endmodule

// File: tb/irq_cause_word_bench.sv
`timescale 1ns/1ps
module irq_cause_word_bench;

  logic        clk_i = 1'b0;
  logic        rst_ni;
  logic [7:0]  evt_i;
  logic        txfail_en_i;
  logic [1:0]  cmd_state_i;
  logic [3:0]  rx_state_i;
  logic        wr_i;
  logic [1:0]  be_i;
  logic [15:0] wdata_i;
  logic [15:0] rdata_o, rdata_np;
  logic        irq_o, irq_np;

  int n_checks = 0;
  int n_fail   = 0;
  logic [7:0] exp_c, exp_np;

  always #2.5 clk_i = ~clk_i;

  irq_cause_word u_irq_cause_word (
    .clk_i, .rst_ni, .evt_i, .txfail_en_i, .cmd_state_i, .rx_state_i,
    .wr_i, .be_i, .wdata_i, .rdata_o, .irq_o
  );

  irq_cause_word #(.HAS_PAUSE(1'b0)) u_irq_cause_word_np (
    .clk_i, .rst_ni, .evt_i, .txfail_en_i, .cmd_state_i, .rx_state_i,
    .wr_i, .be_i, .wdata_i, .rdata_o(rdata_np), .irq_o(irq_np)
  );

  function automatic logic [7:0] model(input logic [7:0] cur, input logic [7:0] ev,
                                       input logic w, input logic [1:0] be,
                                       input logic [15:0] wd, input logic ten,
                                       input logic hp);
    logic [7:0] e, a;
    e = ev;
    if (!ten) e[1] = 1'b0;
    if (!hp)  e[0] = 1'b0;
    a = (w && be[1]) ? wd[15:8] : 8'h00;
    return (cur & ~a) | e;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    chk({tag, " R2 cause byte"}, {24'd0, rdata_o[15:8]}, {24'd0, exp_c});
    chk({tag, " R7 irq level"}, {31'd0, irq_o}, {31'd0, (exp_c != 8'h00)});
    chk({tag, " R1 lower byte"}, {24'd0, rdata_o[7:0]}, {24'd0, cmd_state_i, rx_state_i, 2'b00});
    chk({tag, " R8 no-pause cause byte"}, {24'd0, rdata_np[15:8]}, {24'd0, exp_np});
  endtask

  task automatic step(input logic [7:0] ev, input logic w, input logic [1:0] be,
                      input logic [15:0] wd, input logic ten, input string tag);
    evt_i = ev; wr_i = w; be_i = be; wdata_i = wd; txfail_en_i = ten;
    exp_c  = model(exp_c,  ev, w, be, wd, ten, 1'b1);
    exp_np = model(exp_np, ev, w, be, wd, ten, 1'b0);
    @(negedge clk_i);
    evt_i = 8'h00; wr_i = 1'b0;
    check_all(tag);
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    evt_i = 8'h00; wr_i = 1'b0; be_i = 2'b00; wdata_i = 16'h0000; txfail_en_i = 1'b0;
    exp_c = 8'h00; exp_np = 8'h00;
    repeat (3) @(negedge clk_i);
    check_all("R11 during reset");
    rst_ni = 1'b1;
    repeat (4) @(negedge clk_i);
    check_all("R11 after reset");
  endtask

  initial begin
    #(200000 * 5);
    n_fail++;
    n_checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    logic irq_dropped;
    void'($urandom(32'd20240611));
    cmd_state_i = 2'b10; rx_state_i = 4'b0110;
    do_reset();

    step(8'h05, 1'b0, 2'b00, 16'h0, 1'b0, "R2 set pause and bit2");
    step(8'h00, 1'b0, 2'b00, 16'h0, 1'b0, "R2 sticky");
    step(8'h00, 1'b1, 2'b10, 16'h0400, 1'b0, "R3 R5 partial ack irq held");
    step(8'h00, 1'b1, 2'b10, 16'h0100, 1'b0, "R5 last ack drops irq");
    step(8'h00, 1'b1, 2'b10, 16'hFF00, 1'b0, "R4 ack non-pending");
    step(8'h02, 1'b0, 2'b00, 16'h0, 1'b0, "R9 txfail disabled");
    step(8'h02, 1'b0, 2'b00, 16'h0, 1'b1, "R9 txfail enabled");
    step(8'h10, 1'b1, 2'b10, 16'h1000, 1'b0, "R6 event beats ack");
    step(8'h80, 1'b0, 2'b00, 16'h0, 1'b0, "R7 new event irq stays high");
    step(8'h00, 1'b1, 2'b01, 16'hFFFF, 1'b0, "R10 lower-byte write ignored");
    step(8'h00, 1'b1, 2'b00, 16'hFFFF, 1'b0, "R10 no-enable write ignored");
    step(8'h00, 1'b1, 2'b11, 16'h7F00, 1'b0, "R3 zero bit keeps value");
    step(8'h01, 1'b0, 2'b00, 16'h0, 1'b0, "R8 pause on both builds");

    irq_dropped = 1'b0;
    for (int i = 0; i < 4000; i++) begin
      logic [7:0] ev;
      logic w;
      logic [15:0] wd;
      ev = ($urandom % 4 == 0) ? 8'($urandom) : 8'h00;
      w  = ($urandom % 3 == 0);
      wd = 16'($urandom);
      if ($urandom % 4 == 0) wd[15:8] = exp_c;
      cmd_state_i = 2'($urandom);
      rx_state_i  = 4'($urandom);
      step(ev, w, 2'($urandom), wd, 1'($urandom), "R1 R3 R6 random");
    end

    cmd_state_i = 2'b01; rx_state_i = 4'b1001;
    step(8'hFF, 1'b0, 2'b00, 16'h0, 1'b1, "R7 all set");
    do_reset();
    chk("R11 reset clears irq", {31'd0, irq_o}, 32'd0);

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule